// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single timer channel built around a 16-bit down-counter. A host-side loader hands it an operating mode, a binary or decimal (BCD) counting choice, and an initial count. The channel then steps its count on each falling edge of a slow counting clock. It watches a gate input for level and rising-edge triggers, and drives one output pin whose waveform depends on the selected mode.

Six modes are supported:

- interrupt on terminal count
- gate-retriggered one-shot
- rate generator
- square wave
- write-triggered strobe
- gate-triggered strobe

The counting clock and the gate are both sampled in the system clock domain. The live count is presented on a port so that an outer latch can capture it. Bus decoding and byte sequencing are left to the surrounding logic. The count arrives here as one 16-bit word.

Top module: `tmr_channel`

## Requirements
- R1: After reset the count reads 0 and the output is high. No counting happens until a mode and a count have been written.
- R2: The count changes only on a counting-clock falling edge. This edge is seen as a 1-to-0 change of cnt_clk between two system clocks. A rising edge, or no edge at all, leaves the count unchanged.
- R3: In binary the decrement of 0 gives 0xFFFF, so a loaded 0 acts as 65536. In modes 0, 1, 4 and 5 counting continues past zero by wrapping.
- R4: In BCD each 4-bit digit is decimal and borrows into the next digit. 0x0000 steps to 0x9999, 0x0010 to 0x0009, and 0x1000 to 0x0999.
- R5: Mode 0 behaves as follows:
  - Writing the mode-0 setting or a new count drives the output low.
  - The count loads on the next counting edge.
  - It decrements only while the gate is high.
  - The output rises when the count reaches 0 and stays high after the wrap.
- R6: Mode 1 behaves as follows:
  - The output is high after setup.
  - A gate rising edge loads the count on the next counting edge and drives the output low.
  - The output returns high when the count reaches 0.
  - Without a trigger, nothing reloads.
- R7: Mode 2 behaves as follows:
  - The first counting edge after a count write loads the count.
  - The output goes low for the one count period in which the count is 1.
  - The count then reloads and the output goes high, giving a period of N counting edges.
- R8: In mode 3 the output is high for (N+1)/2 counting edges and low for N/2 edges (rounded down), starting from the load. The count reloads after it reaches 1.
- R9: In modes 2 and 3, a low gate forces the output high and pauses the count. A gate rising edge reloads the initial count on the next counting edge.
- R10: Mode 4 behaves as follows:
  - The edge after a count write loads the count.
  - The output pulses low for exactly one count period when the count reaches 0, and only once per load.
  - A count written mid-run is loaded on the next counting edge.
- R11: Mode 5 behaves as follows:
  - Only a gate rising edge starts a run, with the load on the next counting edge.
  - The output pulses low for one period at 0.
  - A count written mid-run is unused until the next trigger.
- R12: The mode field is 3 bits. Values 0 to 5 select modes 0 to 5, and values 6 and 7 act as modes 2 and 3.
- R13: A gate rising edge is remembered until the next counting-clock falling edge, which consumes it even when the two are several system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clk | input | 1 | Counting clock, sampled; falling edge steps the channel |
| gate | input | 1 | Gate: level enable and rising-edge trigger |
| cfg_wr | input | 1 | One-cycle strobe that takes cfg_mode and cfg_bcd |
| cfg_mode | input | 3 | Operating mode number |
| cfg_bcd | input | 1 | 1 = BCD counting, 0 = binary |
| cnt_wr | input | 1 | One-cycle strobe that takes cnt_val as the initial count |
| cnt_val | input | 16 | Initial count |
| out | output | 1 | Channel output pin |
| count | output | 16 | Live count for external latching |

## Verification
A wrong count or a bad borrow shows on the count port at the first counting edge after the load. The decrement tests catch it within two counting edges of the write. A mistake in the output state shows as an early or late edge on out. For the periodic modes this appears within one full period of N edges. For the strobe modes it appears within the single cycle after zero. A lost or stale trigger flag shows as a missing or repeated load on the first counting edge after the gate edge.

// File: rtl/tmrch_pkg.sv
package tmrch_pkg;

  typedef enum logic [2:0] {
    MD_EVENT    = 3'd0,
    MD_ONESHOT  = 3'd1,
    MD_RATE     = 3'd2,
    MD_SQUARE   = 3'd3,
    MD_SWSTROBE = 3'd4,
    MD_HWSTROBE = 3'd5
  } mode_t;

  // Codes 6 and 7 fold onto the rate and square-wave modes.
  function automatic mode_t map_mode(input logic [2:0] code);
    mode_t m;
    case (code)
      3'd6:    m = MD_RATE;
      3'd7:    m = MD_SQUARE;
      default: m = mode_t'(code);
    endcase
    return m;
  endfunction

endpackage

// File: rtl/tmrch_edges.sv
module tmrch_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_clk,
  input  logic gate,
  output logic tick,
  output logic trig,
  output logic gate_lvl
);

  logic cclk_q, gate_q, trig_q, trig_d;
  logic rise;

  assign tick     = cclk_q & ~cnt_clk;
  assign rise     = gate & ~gate_q;
  assign trig     = trig_q | rise;
  assign gate_lvl = gate_q;

  always_comb begin
    trig_d = trig_q;
    if (tick)      trig_d = 1'b0;
    else if (rise) trig_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cclk_q <= 1'b0;
      gate_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      cclk_q <= cnt_clk;
      gate_q <= gate;
      trig_q <= trig_d;
    end
  end

  AST_TRIG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q && !tick) |=> trig_q); // R13
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2

endmodule

// File: rtl/tmrch_arith.sv
module tmrch_arith #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  output logic [W-1:0] dec_o,
  output logic [W-1:0] half_o
);

  localparam int DIG = W / 4;

  logic [DIG:0]   borrow;
  logic [DIG:0]   rem;
  logic [W-1:0]   bcd_dec, bcd_half;

  assign borrow[0] = 1'b1;
  assign rem[DIG]  = 1'b0;

  for (genvar i = 0; i < DIG; i++) begin : g_dig
    logic [3:0] d;
    logic [4:0] t;
    assign d = val[4*i +: 4];
    // decimal digit with borrow into the next digit
    assign bcd_dec[4*i +: 4] = !borrow[i] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
    assign borrow[i+1]       = borrow[i] && (d == 4'd0);
    // decimal halving, remainder flows toward the low digits
    assign t                  = {1'b0, d} + (rem[i+1] ? 5'd10 : 5'd0);
    assign bcd_half[4*i +: 4] = t[4:1];
    assign rem[i]             = t[0];
  end

  always_comb begin
    if (bcd) begin
      dec_o  = bcd_dec;
      half_o = (val == '0) ? {4'h5, {(W-4){1'b0}}} : bcd_half;
    end else begin
      dec_o  = val - 1'b1;
      half_o = (val == '0) ? {1'b1, {(W-1){1'b0}}} : (val >> 1);
    end
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_clk,
  input  logic         gate,
  input  logic         cfg_wr,
  input  logic [2:0]   cfg_mode,
  input  logic         cfg_bcd,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_val,
  output logic         out,
  output logic [W-1:0] count
);
  import tmrch_pkg::*;

  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  logic tick, trig, gate_lvl;
  logic [W-1:0] dec_v, half_v;

  mode_t        mode_q, mode_d;
  logic         bcd_q, bcd_d;
  logic [W-1:0] cnt_q, cnt_d, init_q, init_d;
  logic         out_q, out_d, run_q, run_d, pend_q, pend_d;
  logic         have_q, have_d, fired_q, fired_d;

  tmrch_edges u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_clk  (cnt_clk),
    .gate     (gate),
    .tick     (tick),
    .trig     (trig),
    .gate_lvl (gate_lvl)
  );

  tmrch_arith #(.W(W)) u_arith (
    .val    (cnt_q),
    .bcd    (bcd_q),
    .dec_o  (dec_v),
    .half_o (half_v)
  );

  logic [W-1:0] init_half;
  tmrch_arith #(.W(W)) u_half (
    .val    (init_q),
    .bcd    (bcd_q),
    .dec_o  (),
    .half_o (init_half)
  );

  always_comb begin
    mode_d  = mode_q;
    bcd_d   = bcd_q;
    cnt_d   = cnt_q;
    init_d  = init_q;
    out_d   = out_q;
    run_d   = run_q;
    pend_d  = pend_q;
    have_d  = have_q;
    fired_d = fired_q;
    if (cfg_wr) begin
      mode_d  = map_mode(cfg_mode);
      bcd_d   = cfg_bcd;
      out_d   = (map_mode(cfg_mode) != MD_EVENT);
      run_d   = 1'b0;
      pend_d  = 1'b0;
      have_d  = 1'b0;
      fired_d = 1'b0;
    end else begin
      if (cnt_wr) begin
        init_d = cnt_val;
        have_d = 1'b1;
        if (mode_q != MD_ONESHOT && mode_q != MD_HWSTROBE) pend_d = 1'b1;
        if (mode_q == MD_EVENT) begin
          out_d = 1'b0;
          run_d = 1'b0;
        end
      end
      if (tick) begin
        case (mode_q)
          MD_EVENT: begin
            if (pend_q) begin
              cnt_d = init_q; run_d = 1'b1; pend_d = 1'b0;
            end else if (run_q && gate_lvl) begin
              cnt_d = dec_v;
              if (dec_v == ZERO) out_d = 1'b1;
            end
          end
          MD_SWSTROBE: begin
            if (!out_q) out_d = 1'b1;
            if (pend_q) begin
              cnt_d = init_q; run_d = 1'b1; pend_d = 1'b0; fired_d = 1'b0;
            end else if (run_q && gate_lvl) begin
              cnt_d = dec_v;
              if (dec_v == ZERO && !fired_q) begin
                out_d = 1'b0; fired_d = 1'b1;
              end
            end
          end
          MD_ONESHOT: begin
            if (trig && have_q) begin
              cnt_d = init_q; run_d = 1'b1; out_d = 1'b0;
            end else if (run_q) begin
              cnt_d = dec_v;
              if (dec_v == ZERO) out_d = 1'b1;
            end
          end
          MD_HWSTROBE: begin
            if (!out_q) out_d = 1'b1;
            if (trig && have_q) begin
              cnt_d = init_q; run_d = 1'b1; fired_d = 1'b0;
            end else if (run_q) begin
              cnt_d = dec_v;
              if (dec_v == ZERO && !fired_q) begin
                out_d = 1'b0; fired_d = 1'b1;
              end
            end
          end
          default: begin // rate and square wave
            if (pend_q || (trig && run_q)) begin
              cnt_d = init_q; run_d = 1'b1; pend_d = 1'b0; out_d = 1'b1;
            end else if (run_q && gate_lvl) begin
              if (cnt_q == ONE) begin
                cnt_d = init_q; out_d = 1'b1;
              end else begin
                cnt_d = dec_v;
                if (mode_q == MD_RATE && dec_v == ONE) out_d = 1'b0;
                if (mode_q == MD_SQUARE && dec_v == init_half) out_d = 1'b0;
              end
            end
          end
        endcase
      end
      if ((mode_q == MD_RATE || mode_q == MD_SQUARE) && !gate_lvl) out_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_EVENT;
      bcd_q   <= 1'b0;
      cnt_q   <= '0;
      init_q  <= '0;
      out_q   <= 1'b1;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      have_q  <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      bcd_q   <= bcd_d;
      cnt_q   <= cnt_d;
      init_q  <= init_d;
      out_q   <= out_d;
      run_q   <= run_d;
      pend_q  <= pend_d;
      have_q  <= have_d;
      fired_q <= fired_d;
    end
  end

  assign out   = out_q;
  assign count = cnt_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cfg_wr) |=> $stable(cnt_q)); // R2
  AST_EVENT_CFG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && map_mode(cfg_mode) == MD_EVENT) |=> !out_q); // R5
  AST_ONESHOT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_ONESHOT && tick && trig && have_q && !cfg_wr) |=> !out_q); // R6
  AST_RATE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_RATE && tick && gate_lvl && run_q && !pend_q && !trig &&
     cnt_q == ONE && !cfg_wr && !cnt_wr) |=> (cnt_q == $past(init_q))); // R7
  AST_GATE_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_RATE || mode_q == MD_SQUARE) && !gate_lvl && !cfg_wr) |=> out_q); // R9
  AST_STROBE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_SWSTROBE || mode_q == MD_HWSTROBE) && !out_q && tick && !cfg_wr)
    |=> out_q); // R10

endmodule

// File: tb/sim_tmr_channel.sv
module sim_tmr_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_clk = 1'b0;
  logic        gate = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_mode = 3'd0;
  logic        cfg_bcd = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_val = 16'd0;
  logic        out;
  logic [15:0] count;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  tmr_channel u0 (
    .clk(clk), .rst_n(rst_n), .cnt_clk(cnt_clk), .gate(gate),
    .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val), .out(out), .count(count)
  );

  // {bcd, initial count, value after one decrement}
  localparam logic [32:0] VEC [0:7] = '{
    {1'b0, 16'h0005, 16'h0004},
    {1'b0, 16'h0000, 16'hFFFF},
    {1'b0, 16'h0100, 16'h00FF},
    {1'b1, 16'h0000, 16'h9999},
    {1'b1, 16'h0010, 16'h0009},
    {1'b1, 16'h1000, 16'h0999},
    {1'b1, 16'h0450, 16'h0449},
    {1'b1, 16'h0001, 16'h0000}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cclk();
    @(negedge clk) cnt_clk = 1'b1;
    @(negedge clk) cnt_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg(input logic [2:0] m, input logic b);
    @(negedge clk) begin cfg_mode = m; cfg_bcd = b; cfg_wr = 1'b1; end
    @(negedge clk) cfg_wr = 1'b0;
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk) begin cnt_val = v; cnt_wr = 1'b1; end
    @(negedge clk) cnt_wr = 1'b0;
  endtask

  task automatic gset(input logic g);
    @(negedge clk) gate = g;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset count", count, 0);
    chk("R1 reset out", out, 1);

    // decrement table, mode 0, gate high
    gset(1'b1);
    for (int i = 0; i < 8; i++) begin
      cfg(3'd0, VEC[i][32]);
      wr(VEC[i][31:16]);
      cclk();
      chk("R3/R4 load", count, VEC[i][31:16]);
      cclk();
      chk(VEC[i][32] ? "R4 bcd dec" : "R3 bin dec", count, VEC[i][15:0]);
    end

    // R2: no falling edge, no change
    hold = count;
    @(negedge clk) cnt_clk = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 rising edge only", count, hold);
    @(negedge clk) cnt_clk = 1'b0;
    @(negedge clk);
    chk("R2 falling edge steps", count, 16'h9999);

    // R5 mode 0 with gate pause
    cfg(3'd0, 1'b0);
    chk("R5 out low after setup", out, 0);
    wr(16'd3);
    cclk(); chk("R5 load", count, 3);
    gset(1'b0);
    cclk(); chk("R5 gate pause", count, 3);
    gset(1'b1);
    cclk(); cclk();
    chk("R5 count 1", count, 1);
    chk("R5 out still low", out, 0);
    cclk(); chk("R5 out high at zero", out, 1);
    cclk(); chk("R3 wrap mode0", count, 16'hFFFF);
    chk("R5 out stays high", out, 1);

    // R6 / R13 mode 1
    gset(1'b0);
    cfg(3'd1, 1'b0);
    wr(16'd4);
    hold = count;
    cclk();
    chk("R6 no trigger no load", count, hold);
    chk("R6 out high", out, 1);
    gset(1'b1);
    cclk();
    chk("R13 held trigger loads", count, 4);
    chk("R6 out low after trigger", out, 0);
    cclk(); cclk(); cclk();
    chk("R6 count 1 out low", out, 0);
    cclk();
    chk("R6 out high at zero", out, 1);
    cclk();
    chk("R13 trigger consumed", count, 16'hFFFF);

    // R7 mode 2, N=3
    cfg(3'd2, 1'b0);
    wr(16'd3);
    begin
      logic [5:0] exp_o;
      exp_o = 6'b110110; // load,2,1,reload,2,1
      for (int k = 0; k < 6; k++) begin
        cclk();
        chk("R7 rate out", out, exp_o[5-k]);
      end
    end
    chk("R7 count at 1", count, 1);

    // R8 mode 3, N=5 then N=4
    cfg(3'd3, 1'b0);
    wr(16'd5);
    begin
      logic [9:0] exp_o;
      exp_o = 10'b1110011100;
      for (int k = 0; k < 10; k++) begin
        cclk();
        chk("R8 odd square", out, exp_o[9-k]);
      end
    end
    cfg(3'd3, 1'b0);
    wr(16'd4);
    begin
      logic [7:0] exp_o;
      exp_o = 8'b11001100;
      for (int k = 0; k < 8; k++) begin
        cclk();
        chk("R8 even square", out, exp_o[7-k]);
      end
    end

    // R9 gate in mode 3: restart N=4
    cclk(); cclk(); cclk();
    chk("R9 low phase", out, 0);
    chk("R9 count", count, 2);
    gset(1'b0);
    chk("R9 forced high", out, 1);
    cclk();
    chk("R9 paused", count, 2);
    gset(1'b1);
    cclk();
    chk("R9 reload on rise", count, 4);
    chk("R9 out high after reload", out, 1);

    // R10 mode 4
    cfg(3'd4, 1'b0);
    wr(16'd3);
    cclk(); chk("R10 load", count, 3);
    cclk(); cclk();
    chk("R10 out high before zero", out, 1);
    cclk(); chk("R10 strobe low", out, 0);
    cclk(); chk("R10 strobe one period", out, 1);
    chk("R3 wrap mode4", count, 16'hFFFF);
    cclk(); chk("R10 no second strobe", out, 1);
    wr(16'd5);
    cclk(); chk("R10 retrigger load", count, 5);
    cclk(); chk("R10 counts on", count, 4);

    // R11 mode 5
    gset(1'b0);
    cfg(3'd5, 1'b0);
    wr(16'd3);
    hold = count;
    cclk(); chk("R11 write alone no load", count, hold);
    gset(1'b1);
    cclk(); chk("R11 trigger load", count, 3);
    cclk();
    wr(16'd7);
    cclk(); chk("R11 mid write ignored", count, 1);
    cclk(); chk("R11 strobe low", out, 0);
    cclk(); chk("R11 strobe ends", out, 1);
    gset(1'b0);
    gset(1'b1);
    cclk(); chk("R11 new count on trigger", count, 7);

    // R12 code 6 acts as rate mode
    cfg(3'd6, 1'b0);
    wr(16'd2);
    cclk(); chk("R12 alias load", count, 2);
    chk("R12 alias out high", out, 1);
    cclk(); chk("R12 alias low at 1", out, 0);
    cclk(); chk("R12 alias reload", count, 2);
    chk("R12 alias out high again", out, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule